// File: doc/BRIEF.md
# Vector Narrowing Move Unit

This unit is one SIMD execution stage. It takes a 128-bit source vector and returns a 64-bit vector. Each narrow output lane keeps only the low half of the matching wide input lane. Lanes keep their order, and lane 0 sits at the least significant bits. A 2-bit size code picks the output lane width: 8, 16 or 32 bits, giving 8, 4 or 2 lanes.

The unit also decodes the operand fields. The destination register number is built from a high bit and a 4-bit field. The 128-bit source register number is built the same way and then halved. Two encodings are illegal: the reserved size code, and an odd low source field. For either one the unit raises an undefined flag and drives zero data instead of a result.

Operations enter through a valid/ready handshake. Results leave one cycle later from a single output register that holds under back-pressure. The latency is the same for every lane width and every data value.

Top module: `vnarrow_unit`

## Requirements
- R1: With size code 00, output lane e (bits 8e+7..8e, e = 0..7) equals bits 16e+7..16e of the source, whatever the sign of the source lane.
- R2: With size code 01, output lane e (bits 16e+15..16e, e = 0..3) equals bits 32e+15..32e of the source.
- R3: With size code 10, output lane e (bits 32e+31..32e, e = 0..1) equals bits 64e+31..64e of the source.
- R4: Size code 11 sets the undefined flag and forces the output data to zero.
- R5: A source low field with bit 0 set sets the undefined flag and forces the output data to zero. The destination number is still reported.
- R6: The destination number equals {dstHi, dstLo}, with dstHi as bit 4.
- R7: The source register number equals {srcHi, srcLo} shifted right by one, which is {srcHi, srcLo[3:1]}.
- R8: An operation accepted at a clock edge appears on the outputs, with outValid high, right after that edge. The latency does not depend on the size code or the data.
- R9: inReady is high exactly when outReady is high or outValid is low. While outValid is high and outReady is low, all outputs hold their values.
- R10: After reset, outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be accepted |
| inVec | input | 128 | Wide source vector |
| inSize | input | 2 | Lane size code (00, 01, 10, 11 reserved) |
| dstHi | input | 1 | High bit of destination number |
| dstLo | input | 4 | Low field of destination number |
| srcHi | input | 1 | High bit of source number |
| srcLo | input | 4 | Low field of source number; bit 0 must be zero |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outVec | output | 64 | Narrowed vector, zero when undefined |
| outDest | output | 5 | Destination register number |
| outSrc | output | 4 | 128-bit source register number |
| outUndef | output | 1 | Illegal encoding flag |

## Verification
Directed vectors use the byte index as each byte's value. The low and high halves of every wide lane therefore differ, so a wrong lane pick or half pick shows up at once for each size code. Vectors with the top bit set in every lane show that the unit truncates rather than saturates or sign-handles. Each illegal encoding is offered both alone and together with the other, with full data, to show that the output is zeroed while the destination is kept. A long random phase toggles outReady against a behavioural model of the output register, which covers stalls and back-to-back transfers.

// File: rtl/vnarrow_pkg.sv
package vnarrow_pkg;
  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_H16 = 2'b01,
    SZ_W32 = 2'b10,
    SZ_RSV = 2'b11
  } laneSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      squash;
    laneSize_e size;
  } dpCtrl_t;
endpackage

// File: rtl/vnarrow_dpath.sv
module vnarrow_dpath
  import vnarrow_pkg::*;
#(
  parameter int DST_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [2*DST_W-1:0] srcVec,
  output logic [DST_W-1:0]   resVec
);
  localparam int NUM_SZ = 3;

  logic [NUM_SZ-1:0][DST_W-1:0] cand;
  logic [DST_W-1:0] nxtVec;

  // one fixed wiring pattern per legal lane width
  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = DST_W / LW;
    for (genvar e = 0; e < NL; e++) begin : g_lane
      assign cand[s][e*LW +: LW] = srcVec[e*2*LW +: LW];
    end
  end

  always_comb begin
    case (ctrl.size)
      SZ_B8:   nxtVec = cand[0];
      SZ_H16:  nxtVec = cand[1];
      SZ_W32:  nxtVec = cand[2];
      default: nxtVec = '0;
    endcase
    if (ctrl.squash) nxtVec = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          resVec <= '0;
    else if (ctrl.load) resVec <= nxtVec;
  end
endmodule

// File: rtl/vnarrow_ctrl.sv
module vnarrow_ctrl
  import vnarrow_pkg::*;
#(
  parameter int FLD_W = 4,
  localparam int IDX_W = FLD_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inSize,
  input  logic             dstHi,
  input  logic [FLD_W-1:0] dstLo,
  input  logic             srcHi,
  input  logic [FLD_W-1:0] srcLo,
  output logic             outValid,
  input  logic             outReady,
  output logic [IDX_W-1:0] outDest,
  output logic [FLD_W-1:0] outSrc,
  output logic             outUndef,
  output dpCtrl_t          ctrl
);
  logic accept;
  logic undefNow;
  logic [IDX_W-1:0] srcNum;

  assign inReady  = outReady | ~outValid;
  assign accept   = inValid & inReady;
  assign undefNow = (laneSize_e'(inSize) == SZ_RSV) | srcLo[0];
  assign srcNum   = {srcHi, srcLo};

  assign ctrl.load   = accept;
  assign ctrl.squash = undefNow;
  assign ctrl.size   = laneSize_e'(inSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outDest  <= '0;
      outSrc   <= '0;
      outUndef <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
      outDest  <= {dstHi, dstLo};
      outSrc   <= srcNum[IDX_W-1:1];
      outUndef <= undefNow;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/vnarrow_unit.sv
module vnarrow_unit
  import vnarrow_pkg::*;
#(
  parameter int DST_W = 64,
  parameter int FLD_W = 4,
  localparam int SRC_W = 2 * DST_W,
  localparam int IDX_W = FLD_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [SRC_W-1:0] inVec,
  input  logic [1:0]       inSize,
  input  logic             dstHi,
  input  logic [FLD_W-1:0] dstLo,
  input  logic             srcHi,
  input  logic [FLD_W-1:0] srcLo,
  output logic             outValid,
  input  logic             outReady,
  output logic [DST_W-1:0] outVec,
  output logic [IDX_W-1:0] outDest,
  output logic [FLD_W-1:0] outSrc,
  output logic             outUndef
);
  dpCtrl_t dpCtrl;

  vnarrow_ctrl #(.FLD_W(FLD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSize(inSize), .dstHi(dstHi), .dstLo(dstLo), .srcHi(srcHi),
    .srcLo(srcLo), .outValid(outValid), .outReady(outReady),
    .outDest(outDest), .outSrc(outSrc), .outUndef(outUndef), .ctrl(dpCtrl)
  );

  vnarrow_dpath #(.DST_W(DST_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .srcVec(inVec), .resVec(outVec)
  );
endmodule

// File: rtl/vnarrow_chk.sv
module vnarrow_chk #(
  parameter int DST_W = 64,
  parameter int FLD_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [1:0]       inSize,
  input logic             dstHi,
  input logic [FLD_W-1:0] dstLo,
  input logic [FLD_W-1:0] srcLo,
  input logic             outValid,
  input logic             outReady,
  input logic [DST_W-1:0] outVec,
  input logic [FLD_W:0]   outDest,
  input logic             outUndef
);
  p_undef_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outUndef |-> outVec == '0);

  p_rsv_size_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inSize == 2'b11 |=> outUndef);

  p_odd_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && srcLo[0] |=> outUndef);

  p_dest_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outDest == $past({dstHi, dstLo}));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outVec) && $stable(outDest) && $stable(outUndef));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);
endmodule

bind vnarrow_unit vnarrow_chk #(.DST_W(DST_W), .FLD_W(FLD_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inSize(inSize), .dstHi(dstHi), .dstLo(dstLo), .srcLo(srcLo),
  .outValid(outValid), .outReady(outReady), .outVec(outVec),
  .outDest(outDest), .outUndef(outUndef)
);

// File: tb/vnarrow_unit_bench.sv
module vnarrow_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inVec = '0;
  logic [1:0]   inSize = '0;
  logic         dstHi = 1'b0;
  logic [3:0]   dstLo = '0;
  logic         srcHi = 1'b0;
  logic [3:0]   srcLo = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [63:0]  outVec;
  logic [4:0]   outDest;
  logic [3:0]   outSrc;
  logic         outUndef;

  int checks = 0;
  int fails = 0;
  bit timedOut = 0;

  // reference state for the output register
  bit          mValid = 0;
  logic [63:0] mVec = '0;
  logic [4:0]  mDest = '0;
  logic [3:0]  mSrc = '0;
  bit          mUndef = 0;
  string       mTag = "R1";

  always #4 clk = ~clk;

  vnarrow_unit u_vnarrow_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inVec(inVec), .inSize(inSize), .dstHi(dstHi), .dstLo(dstLo),
    .srcHi(srcHi), .srcLo(srcLo), .outValid(outValid), .outReady(outReady),
    .outVec(outVec), .outDest(outDest), .outSrc(outSrc), .outUndef(outUndef)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] narrowRef(input logic [127:0] v, input int sz);
    logic [63:0] r;
    int w;
    r = '0;
    w = 8 << sz;
    for (int b = 0; b < 64; b++)
      r[b] = v[(b / w) * 2 * w + (b % w)];
    return r;
  endfunction

  // compare outputs with the model, then offer the next stimulus
  task automatic compareAll();
    check(outValid == mValid, "R8", 128'(outValid), 128'(mValid));
    check(inReady == (outReady || mValid == 0), "R9", 128'(inReady), 128'(outReady || !mValid));
    if (mValid) begin
      check(outVec == mVec, mTag, 128'(outVec), 128'(mVec));
      check(outUndef == mUndef, mUndef ? mTag : "R4", 128'(outUndef), 128'(mUndef));
      check(outDest == mDest, "R6", 128'(outDest), 128'(mDest));
      if (!mUndef)
        check(outSrc == mSrc, "R7", 128'(outSrc), 128'(mSrc));
    end
  endtask

  task automatic step(input bit v, input logic [127:0] vec, input logic [1:0] sz,
                      input logic [4:0] dst, input logic [4:0] src, input bit rdy);
    @(negedge clk);
    compareAll();
    inValid = v; inVec = vec; inSize = sz;
    {dstHi, dstLo} = dst; {srcHi, srcLo} = src; outReady = rdy;
    if (v && (rdy || !mValid)) begin
      mValid = 1;
      mUndef = (sz == 2'b11) || src[0];
      mVec   = mUndef ? 64'h0 : narrowRef(vec, int'(sz));
      mDest  = dst;
      mSrc   = src[4:1];
      mTag   = (sz == 2'b11) ? "R4" : src[0] ? "R5" : sz == 0 ? "R1" : sz == 1 ? "R2" : "R3";
    end else if (rdy) begin
      mValid = 0;
    end
  endtask

  logic [127:0] ramp;
  logic [127:0] negs;

  initial begin
    fork
      begin
        repeat (60000) @(posedge clk);
        timedOut = 1;
      end
      begin
        for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(i);
        negs = {16{8'h80}} | {8{16'h8001}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(outValid == 1'b0, "R10", 128'(outValid), 128'(0));
        rstN = 1'b1;
        // lane widths, distinct bytes and sign-heavy data
        step(1, ramp, 2'b00, 5'd3, 5'd4, 1);
        step(1, ramp, 2'b01, 5'd17, 5'd30, 1);
        step(1, ramp, 2'b10, 5'd31, 5'd0, 1);
        step(1, negs, 2'b00, 5'd8, 5'd2, 1);
        step(1, negs, 2'b01, 5'd9, 5'd18, 1);
        step(1, ~ramp, 2'b10, 5'd1, 5'd22, 1);
        // illegal encodings: reserved size, odd source, both
        step(1, ~128'h0, 2'b11, 5'd21, 5'd6, 1);
        step(1, ~128'h0, 2'b00, 5'd12, 5'd7, 1);
        step(1, ~128'h0, 2'b11, 5'd30, 5'd31, 1);
        // stall: output must hold, new offers refused
        step(1, ramp, 2'b01, 5'd5, 5'd10, 0);
        step(1, negs, 2'b00, 5'd6, 5'd12, 0);
        step(1, negs, 2'b00, 5'd6, 5'd12, 0);
        step(0, '0, 2'b00, 5'd0, 5'd0, 1);
        step(0, '0, 2'b00, 5'd0, 5'd0, 1);
        // random traffic with back-pressure
        for (int n = 0; n < 3000; n++)
          step($urandom_range(0, 3) != 0, {$urandom, $urandom, $urandom, $urandom},
               2'($urandom), 5'($urandom), 5'($urandom), $urandom_range(0, 2) != 0);
        step(0, '0, 2'b00, 5'd0, 5'd0, 1);
        @(negedge clk);
        compareAll();
      end
    join_any
    if (timedOut) check(0, "R8", 128'(0), 128'(1));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule